// File: doc/BRIEF.md
# Smart Card Contact Sequencer

This block runs the power-up and power-down order of the contacts of one or more smart card slots. For each slot it drives the supply-enable line and the supply-level select, gates the reset and data lines that host software drives, and gates a shared card clock source onto that slot's clock contact. Each slot has its own sequencer instance, and the slots run independently of each other.

When a slot's enable goes high, its supply enable is asserted and its reset, clock and data contacts are held low. The block then waits for the regulator to report that the supply is good. After that it counts a settling delay in system-clock cycles and releases reset and data to software control. The card clock is let through starting on the second rising edge of the clock source after that release, and the gate only ever switches while the source is low. When enable drops, whether during a session or part-way through activation, reset is forced low first. The clock then stops after two further source cycles, unless it was not running. Data is forced low next, then the supply is switched off, and the slot reports idle.

Top module: `cardslot_seq_top`

## Requirements
- R1: After reset every slot reports idle (idle=1) and drives supply enable, card reset, card data and card clock low.
- R2: From activation until release, card reset, card data and card clock stay low while supply enable is high.
- R3: Reset and data are released exactly SETTLE_CYC system cycles after the first clock edge that samples supply-good high (SETTLE_CYC = SYS_FREQ_HZ/1000 * SETTLE_US/1000).
- R4: The card clock output first goes high on the second rising edge of the clock source seen after release, and stays low before it.
- R5: On the first system edge that samples enable low in a session, card reset is forced low while data and supply stay unchanged.
- R6: After enable drops with the clock running, the card clock makes exactly two more falling transitions and then stays low. If the clock was not yet running, it never goes high.
- R7: After the clock stops, data goes low one system cycle later, supply enable drops one cycle after that, and idle rises one cycle after that.
- R8: Enable going low during supply ramp or while waiting for the clock aborts straight into the deactivation order of R5 to R7.
- R9: The clock gate changes state only while the sampled clock source is low, so no shortened card clock pulse is produced.
- R10: The supply-level select output takes the select input at activation and ignores later changes of it until the next activation.
- R11: Each slot sequences independently; a slot whose enable stays low remains idle and unpowered while another slot runs.
- R12: Supply enable goes high and idle goes low on the first system edge that samples enable high in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_src | input | 1 | Card clock source, synchronous to clk, half period at least two clk cycles |
| en | input | NUM_SLOTS | Per-slot session enable |
| sup_good | input | NUM_SLOTS | Per-slot supply-good indication from the regulator |
| vsel | input | NUM_SLOTS | Per-slot supply level request (0 = low level, 1 = high level) |
| sw_rst | input | NUM_SLOTS | Reset level requested by software |
| sw_io | input | NUM_SLOTS | Data level requested by software |
| sup_en | output | NUM_SLOTS | Supply enable to the regulator |
| vsel_o | output | NUM_SLOTS | Latched supply level select to the regulator |
| card_rst | output | NUM_SLOTS | Card reset contact |
| card_io | output | NUM_SLOTS | Card data contact drive level |
| card_clk | output | NUM_SLOTS | Card clock contact |
| idle | output | NUM_SLOTS | Slot fully deactivated |

## Verification
The hardest cases to reach are the moment enable drops relative to the phase of the card clock, and an abort during the short window between release and the first clock pulse. Both decide whether the clock stops after two cycles or never starts. The bench follows the card clock output and the release of reset at the ports. It drops enable once in the middle of a high phase, once in the middle of a low phase, and once on the very cycle reset is released. It then counts clock transitions and the cycle spacing of data, supply and idle.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAMP,
        ST_SETTLE,
        ST_ARM,
        ST_ACTIVE,
        ST_DRST,
        ST_DIO,
        ST_DSUP
    } slot_state_e;

endpackage

// File: rtl/card_settle_timer.sv
module card_settle_timer #(
    parameter int CYCLES = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        done  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (!done)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R3

    AST_TIMER_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> (cnt_q == '0)); // R3

endmodule

// File: rtl/card_clk_gate.sv
module card_clk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic arm_i,
    input  logic stop_i,
    output logic gate_o,
    output logic card_clk_o
);
    typedef struct packed {
        logic       src;
        logic       gate;
        logic       clk_out;
        logic [1:0] rise_cnt;
        logic [1:0] fall_cnt;
    } gate_reg_t;

    gate_reg_t q, d;
    logic rise, fall;

    always_comb begin
        rise = src_i && !q.src;
        fall = !src_i && q.src;
        d     = q;
        d.src = src_i;

        if (arm_i) begin
            if (rise) begin
                if (q.rise_cnt == 2'd1 && !q.gate)
                    d.gate = 1'b1;
                if (q.rise_cnt != 2'd2)
                    d.rise_cnt = q.rise_cnt + 2'd1;
            end
        end else begin
            d.rise_cnt = 2'd0;
        end

        if (stop_i) begin
            if (fall && q.fall_cnt != 2'd2)
                d.fall_cnt = q.fall_cnt + 2'd1;
            if (q.gate && q.fall_cnt == 2'd2 && !src_i && !q.src)
                d.gate = 1'b0;
        end else begin
            d.fall_cnt = 2'd0;
        end

        d.clk_out = src_i && d.gate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign gate_o     = q.gate;
    assign card_clk_o = q.clk_out;

    logic src_seen;
    assign src_seen = q.src;

    AST_GATE_SRC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gate_o) |-> !$past(src_seen)); // R9

    AST_GATE_ON_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> $past(arm_i)); // R4

    AST_GATE_OFF_STOPPING: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_o) |-> $past(stop_i)); // R6

endmodule

// File: rtl/card_slot_fsm.sv
module card_slot_fsm
    import card_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sup_good,
    input  logic vsel,
    input  logic gate_on,
    input  logic timer_done,
    output logic timer_run,
    output logic arm,
    output logic stop,
    output logic sup_en,
    output logic vsel_o,
    output logic rst_rel,
    output logic io_rel,
    output logic idle
);
    typedef struct packed {
        slot_state_e state;
        logic        vsel;
    } fsm_reg_t;

    fsm_reg_t q, d;

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (en) begin
                    d.state = ST_RAMP;
                    d.vsel  = vsel;
                end
            end
            ST_RAMP: begin
                if (!en)
                    d.state = ST_DRST;
                else if (sup_good)
                    d.state = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (!en)
                    d.state = ST_DRST;
                else if (timer_done)
                    d.state = ST_ARM;
            end
            ST_ARM: begin
                if (!en)
                    d.state = ST_DRST;
                else if (gate_on)
                    d.state = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (!en)
                    d.state = ST_DRST;
            end
            ST_DRST: begin
                if (!gate_on)
                    d.state = ST_DIO;
            end
            ST_DIO:  d.state = ST_DSUP;
            ST_DSUP: d.state = ST_IDLE;
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.vsel  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign timer_run = (q.state == ST_SETTLE);
    assign arm       = (q.state == ST_ARM);
    assign stop      = (q.state == ST_DRST);
    assign sup_en    = (q.state != ST_IDLE) && (q.state != ST_DSUP);
    assign rst_rel   = (q.state == ST_ARM) || (q.state == ST_ACTIVE);
    assign io_rel    = rst_rel || (q.state == ST_DRST);
    assign idle      = (q.state == ST_IDLE);
    assign vsel_o    = q.vsel;

    AST_QUIET_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RAMP || q.state == ST_SETTLE) |-> (!io_rel && !rst_rel && !gate_on)); // R2

    AST_RESET_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_rel) && !rst_rel && sup_en) |-> io_rel || !$past(io_rel)); // R5

    AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && (q.state == ST_RAMP || q.state == ST_SETTLE || q.state == ST_ARM)) |=> (q.state == ST_DRST)); // R8

    AST_VSEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !idle && $past(!idle) |-> $stable(vsel_o)); // R10

endmodule

// File: rtl/card_slot.sv
module card_slot #(
    parameter int SETTLE_CYC = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_src,
    input  logic en,
    input  logic sup_good,
    input  logic vsel,
    input  logic sw_rst,
    input  logic sw_io,
    output logic sup_en,
    output logic vsel_o,
    output logic card_rst,
    output logic card_io,
    output logic card_clk,
    output logic idle
);
    logic timer_run, timer_done, arm, stop, gate_on, rst_rel, io_rel;

    card_slot_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .sup_good   (sup_good),
        .vsel       (vsel),
        .gate_on    (gate_on),
        .timer_done (timer_done),
        .timer_run  (timer_run),
        .arm        (arm),
        .stop       (stop),
        .sup_en     (sup_en),
        .vsel_o     (vsel_o),
        .rst_rel    (rst_rel),
        .io_rel     (io_rel),
        .idle       (idle)
    );

    card_settle_timer #(.CYCLES(SETTLE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timer_run),
        .done  (timer_done)
    );

    card_clk_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (clk_src),
        .arm_i      (arm),
        .stop_i     (stop),
        .gate_o     (gate_on),
        .card_clk_o (card_clk)
    );

    assign card_rst = rst_rel && sw_rst;
    assign card_io  = io_rel && sw_io;

    AST_IO_BEFORE_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sup_en) |-> (!io_rel && $past(!io_rel))); // R7

    AST_IDLE_AFTER_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> $past(!sup_en)); // R7

    AST_CLK_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        card_clk |-> (sup_en && io_rel)); // R6

    AST_UNPOWERED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_en |-> (!card_rst && !card_io && !card_clk)); // R1

endmodule

// File: rtl/cardslot_seq_top.sv
module cardslot_seq_top #(
    parameter int NUM_SLOTS   = 2,
    parameter int SYS_FREQ_HZ = 50_000_000,
    parameter int SETTLE_US   = 800
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clk_src,
    input  logic [NUM_SLOTS-1:0] en,
    input  logic [NUM_SLOTS-1:0] sup_good,
    input  logic [NUM_SLOTS-1:0] vsel,
    input  logic [NUM_SLOTS-1:0] sw_rst,
    input  logic [NUM_SLOTS-1:0] sw_io,
    output logic [NUM_SLOTS-1:0] sup_en,
    output logic [NUM_SLOTS-1:0] vsel_o,
    output logic [NUM_SLOTS-1:0] card_rst,
    output logic [NUM_SLOTS-1:0] card_io,
    output logic [NUM_SLOTS-1:0] card_clk,
    output logic [NUM_SLOTS-1:0] idle
);
    localparam int SETTLE_CYC_RAW = (SYS_FREQ_HZ / 1000) * SETTLE_US / 1000;
    localparam int SETTLE_CYC     = (SETTLE_CYC_RAW < 2) ? 2 : SETTLE_CYC_RAW;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        card_slot #(.SETTLE_CYC(SETTLE_CYC)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .clk_src  (clk_src),
            .en       (en[s]),
            .sup_good (sup_good[s]),
            .vsel     (vsel[s]),
            .sw_rst   (sw_rst[s]),
            .sw_io    (sw_io[s]),
            .sup_en   (sup_en[s]),
            .vsel_o   (vsel_o[s]),
            .card_rst (card_rst[s]),
            .card_io  (card_io[s]),
            .card_clk (card_clk[s]),
            .idle     (idle[s])
        );
    end

endmodule

// File: tb/tb_cardslot_seq_top.sv
`timescale 1ns/1ps
module tb_cardslot_seq_top;
    localparam int NS = 2;
    localparam int SETTLE_US = 2;
    localparam int N = (50_000_000 / 1000) * SETTLE_US / 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_src = 1'b0;
    logic [NS-1:0] en = '0, sg = '0, vsel = '0, swr = '0, swi = '0;
    logic [NS-1:0] sup_en, vsel_o, card_rst, card_io, card_clk, idle;
    int n_chk = 0;
    int n_fail = 0;

    cardslot_seq_top #(.NUM_SLOTS(NS), .SYS_FREQ_HZ(50_000_000), .SETTLE_US(SETTLE_US)) dut (
        .clk(clk), .rst_n(rst_n), .clk_src(clk_src), .en(en), .sup_good(sg),
        .vsel(vsel), .sw_rst(swr), .sw_io(swi), .sup_en(sup_en), .vsel_o(vsel_o),
        .card_rst(card_rst), .card_io(card_io), .card_clk(card_clk), .idle(idle)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            repeat (4) @(negedge clk);
            clk_src = ~clk_src;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 idle after reset", idle, 2'b11);
        chk("R1 supply low", sup_en, 0);
        chk("R1 contacts low", {card_rst, card_io, card_clk}, 0);
    endtask

    // Bring slot 0 to a running clock; abort_at_release drops enable on the release cycle.
    task automatic t_activate(input bit abort_at_release);
        int bad = 0;
        int early = 0;
        int rises = 0;
        logic prev;
        swr = '1; swi = '1; sg[0] = 1'b0;
        vsel[0] = 1'b1;
        en[0] = 1'b1;
        tick();
        chk("R12 supply on", sup_en[0], 1);
        chk("R12 not idle", idle[0], 0);
        chk("R10 select latched", vsel_o[0], 1);
        vsel[0] = 1'b0;
        for (int i = 0; i < 5; i++) begin
            tick();
            if (card_rst[0] || card_io[0] || card_clk[0]) bad++;
        end
        sg[0] = 1'b1;
        for (int i = 0; i < N; i++) begin
            tick();
            if (card_rst[0] || card_io[0] || card_clk[0]) bad++;
        end
        chk("R2 contacts low while ramping", bad, 0);
        prev = clk_src;
        tick();
        chk("R3 reset released after settle", card_rst[0], 1);
        chk("R3 data released after settle", card_io[0], 1);
        chk("R10 select change ignored", vsel_o[0], 1);
        chk("R11 other slot idle", {idle[1], sup_en[1], card_clk[1]}, 3'b100);
        if (abort_at_release) begin
            en[0] = 1'b0;
            return;
        end
        for (int i = 0; i < 40 && rises < 2; i++) begin
            if (i > 0) tick();
            if (card_clk[0]) early++;
            if (clk_src && !prev) rises++;
            prev = clk_src;
        end
        chk("R4 clock low before second rise", early, 0);
        tick();
        chk("R4 clock starts on second rise", card_clk[0], 1);
    endtask

    task automatic t_deact(input bit high_phase);
        logic prev;
        int falls = 0;
        int guard = 0;
        int late = 0;
        t_activate(1'b0);
        prev = card_clk[0];
        while (guard < 40 && !(card_clk[0] == high_phase && prev != high_phase)) begin
            prev = card_clk[0];
            tick();
            guard++;
        end
        tick();
        en[0] = 1'b0;
        tick();
        chk("R5 reset forced low", card_rst[0], 0);
        chk("R5 data still driven", card_io[0], 1);
        chk("R5 supply still on", sup_en[0], 1);
        prev = card_clk[0];
        guard = 0;
        while (card_io[0] && guard < 60) begin
            tick();
            if (prev && !card_clk[0]) falls++;
            prev = card_clk[0];
            guard++;
        end
        chk(high_phase ? "R6 two cycles (high phase)" : "R6 two cycles (low phase)", falls, 2);
        chk("R7 clock low when data drops", card_clk[0], 0);
        chk("R7 supply on when data drops", sup_en[0], 1);
        tick();
        chk("R7 supply drops next cycle", sup_en[0], 0);
        chk("R7 not idle yet", idle[0], 0);
        tick();
        chk("R7 idle after supply", idle[0], 1);
        for (int i = 0; i < 10; i++) begin
            tick();
            if (card_clk[0]) late++;
        end
        chk("R6 clock stays low", late, 0);
        sg[0] = 1'b0;
    endtask

    task automatic t_abort_arm();
        int hi = 0;
        t_activate(1'b1);
        tick();
        if (card_clk[0]) hi++;
        chk("R8 reset low after abort", card_rst[0], 0);
        chk("R8 data held one cycle", card_io[0], 1);
        tick();
        if (card_clk[0]) hi++;
        chk("R8 data low", card_io[0], 0);
        chk("R8 supply still on", sup_en[0], 1);
        tick();
        if (card_clk[0]) hi++;
        chk("R8 supply off", sup_en[0], 0);
        tick();
        chk("R8 idle", idle[0], 1);
        chk("R6 clock never started", hi, 0);
        sg[0] = 1'b0;
    endtask

    task automatic t_abort_ramp();
        en[0] = 1'b1;
        tick();
        tick();
        en[0] = 1'b0;
        tick();
        chk("R8 ramp abort keeps supply one step", sup_en[0], 1);
        tick();
        tick();
        chk("R8 ramp abort supply off", sup_en[0], 0);
        tick();
        chk("R8 ramp abort idle", idle[0], 1);
    endtask

    task automatic t_indep();
        en[1] = 1'b1;
        tick();
        chk("R11 slot 1 powers up", sup_en[1], 1);
        chk("R11 slot 0 unaffected", {idle[0], sup_en[0]}, 2'b10);
        en[1] = 1'b0;
        repeat (5) tick();
        chk("R11 slot 1 back to idle", idle[1], 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
    end

    initial begin
        t_reset();
        t_deact(1'b1);
        t_deact(1'b0);
        t_abort_arm();
        t_abort_ramp();
        t_indep();
        summary();
    end

endmodule